// File: doc/BRIEF.md
# Privilege-Masked Interrupt CSR Unit

This block keeps the interrupt-enable, interrupt-pending, interrupt-delegation and exception-delegation state of a small hart that runs in machine and user modes. It also holds the trap cause and an interrupt threshold byte. Software reaches these registers through a one-cycle request port that carries the 12-bit CSR address, the write data and the privilege the hart is running at. Bits [9:8] of the address select a privilege view. That view, together with the running privilege, decides which bits a read exposes and which bits a write may change.

From the stored state the block derives the set of interrupts that are pending, enabled and not delegated. It gates that set with the machine-mode global enable and presents it, along with a single request flag, to the trap logic. The machine timer pending bit follows a hardware input and cannot be changed by software.

Top module: `irqcsr_unit`

## Requirements
- R1: After a synchronous reset every register, `csr_rdata`, `irq_vec` and `irq_req` are zero.
- R2: Address bits [9:8] select the view mask: 0 gives 0x111, 1 gives 0x333, 2 gives 0x000 and 3 gives 0x999. The enable register decodes at address low byte 0x04 and the pending register at low byte 0x44, with address bits [11:10] equal to 0.
- R3: A read of enable or pending returns the stored value ANDed with the view mask. When `cur_priv` is not 3 (machine), the result is also ANDed with the interrupt delegation register.
- R4: A write to enable changes only the bits in the view mask, giving (old & ~mask) | (wdata & mask). The same rule applies to pending, with the further limits of R5 and R6.
- R5: Pending bit 7 (machine timer) always equals `timer_irq` as sampled at the previous clock edge. A software write never changes it, even when the write and a change of `timer_irq` fall at the same edge.
- R6: When `cur_priv` is not 3, a pending write cannot change bit 5 or bit 4 (the supervisor and user timer bits).
- R7: Only bits 0, 4 and 8 (mask 0x111) of the interrupt delegation register at address 0x303 are writable. All its other bits read 0.
- R8: The exception delegation register at 0x302 keeps only the bits in 0xF7F7, so bits 3 and 11 and everything above bit 15 read 0.
- R9: A write to the cause register at 0x342 keeps bit XLEN-1 and the code bits below MAX_IRQ. MAX_IRQ is 16, or 16 plus the local interrupt count when local interrupts are enabled. The default configuration keeps mask 0x8000000F.
- R10: A write to the threshold register at 0x347 keeps only wdata[7:0].
- R11: `irq_vec` is pending & enable & ~delegation when `cur_priv` is below 3 or `glob_mie` is 1, and 0 otherwise.
- R12: `irq_vec` and `irq_req` (the OR of `irq_vec`) change one clock after the register update that causes the change, which is two edges after the write request.
- R13: `csr_rdata` is loaded at the edge that samples a request and otherwise holds its value. Addresses not listed above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | CSR access request, one cycle per access |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| cur_priv | input | 2 | Running privilege level (3 = machine) |
| glob_mie | input | 1 | Machine-mode global interrupt enable |
| timer_irq | input | 1 | Machine timer interrupt line |
| csr_rdata | output | XLEN | Registered read data |
| irq_vec | output | 12 | Registered enabled-interrupt set |
| irq_req | output | 1 | Registered interrupt request |

## Verification
A software write to the pending register and a change of the timer line can land on the same clock edge. The bench provokes this by driving `timer_irq` in the same half-cycle as a full-ones pending write. It then reads back that bit 7 follows the line while the other bits take the written data. The sweep over all views and privileges also writes the delegation register immediately before enable and pending. This makes delegation masking and gating meet fresh values, and a bench model computes the expected mask for every combination.

// File: rtl/irqcsr_pkg.sv
package irqcsr_pkg;
  localparam int IRQ_W = 12;
  typedef logic [IRQ_W-1:0] irqv_t;

  localparam irqv_t VIEW_USER  = 12'h111;
  localparam irqv_t VIEW_SUPV  = 12'h333;
  localparam irqv_t VIEW_MACH  = 12'h999;
  localparam irqv_t DELEG_KEEP = 12'h111;

  localparam int BIT_UTMR = 4;
  localparam int BIT_STMR = 5;
  localparam int BIT_MTMR = 7;

  localparam logic [1:0] PRIV_MACH = 2'b11;

  localparam logic [7:0]  OFS_EN   = 8'h04;
  localparam logic [7:0]  OFS_PEND = 8'h44;
  localparam logic [11:0] ADR_IDLG = 12'h303;
  localparam logic [11:0] ADR_EDLG = 12'h302;
  localparam logic [11:0] ADR_CAUS = 12'h342;
  localparam logic [11:0] ADR_THRS = 12'h347;

  localparam logic [15:0] EDLG_KEEP = 16'hF7F7;
  localparam int THRS_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_EN, SEL_PEND, SEL_IDLG, SEL_EDLG, SEL_CAUS, SEL_THRS
  } csr_sel_e;

  function automatic irqv_t view_mask(input logic [1:0] lvl);
    irqv_t m;
    unique case (lvl)
      2'd0:    m = VIEW_USER;
      2'd1:    m = VIEW_SUPV;
      2'd2:    m = '0;
      default: m = VIEW_MACH;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/irqcsr_decode.sv
module irqcsr_decode
  import irqcsr_pkg::*;
(
  input  logic [11:0] addr,
  input  logic [1:0]  priv,
  output csr_sel_e    sel,
  output irqv_t       rd_mask,
  output irqv_t       en_wmask,
  output irqv_t       pend_wmask,
  output logic        priv_m
);
  logic space_ok;

  always_comb begin
    priv_m     = (priv == PRIV_MACH);
    rd_mask    = view_mask(addr[9:8]);
    en_wmask   = rd_mask;
    pend_wmask = rd_mask;
    pend_wmask[BIT_MTMR] = 1'b0;
    if (!priv_m) begin
      pend_wmask[BIT_STMR] = 1'b0;
      pend_wmask[BIT_UTMR] = 1'b0;
    end
  end

  always_comb begin
    space_ok = (addr[11:10] == 2'b00);
    if (space_ok && addr[7:0] == OFS_EN)        sel = SEL_EN;
    else if (space_ok && addr[7:0] == OFS_PEND) sel = SEL_PEND;
    else if (addr == ADR_IDLG)                  sel = SEL_IDLG;
    else if (addr == ADR_EDLG)                  sel = SEL_EDLG;
    else if (addr == ADR_CAUS)                  sel = SEL_CAUS;
    else if (addr == ADR_THRS)                  sel = SEL_THRS;
    else                                        sel = SEL_NONE;
  end
endmodule

// File: rtl/irqcsr_regs.sv
module irqcsr_regs
  import irqcsr_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] CAUSE_KEEP = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  csr_sel_e        sel,
  input  logic [XLEN-1:0] wdata,
  input  irqv_t           en_wmask,
  input  irqv_t           pend_wmask,
  input  logic            timer_irq,
  output irqv_t           en_q,
  output irqv_t           pend_q,
  output irqv_t           idlg_q,
  output logic [XLEN-1:0] edlg_q,
  output logic [XLEN-1:0] caus_q,
  output logic [XLEN-1:0] thrs_q
);
  localparam logic [XLEN-1:0] EDLG_M = XLEN'(EDLG_KEEP);

  irqv_t wlow;
  assign wlow = wdata[IRQ_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      idlg_q <= '0;
      edlg_q <= '0;
      caus_q <= '0;
      thrs_q <= '0;
    end else begin
      if (wr_en) begin
        unique case (sel)
          SEL_EN:   en_q   <= (en_q & ~en_wmask) | (wlow & en_wmask);
          SEL_PEND: pend_q <= (pend_q & ~pend_wmask) | (wlow & pend_wmask);
          SEL_IDLG: idlg_q <= (idlg_q & ~DELEG_KEEP) | (wlow & DELEG_KEEP);
          SEL_EDLG: edlg_q <= (edlg_q & ~EDLG_M) | (wdata & EDLG_M);
          SEL_CAUS: caus_q <= wdata & CAUSE_KEEP;
          SEL_THRS: thrs_q <= XLEN'(wdata[THRS_W-1:0]);
          default:  ;
        endcase
      end
      pend_q[BIT_MTMR] <= timer_irq;
    end
  end
endmodule

// File: rtl/irqcsr_gate.sv
module irqcsr_gate
  import irqcsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  irqv_t      pend,
  input  irqv_t      en,
  input  irqv_t      idlg,
  input  logic [1:0] priv,
  input  logic       glob_mie,
  output irqv_t      vec_q,
  output logic       req_q
);
  irqv_t raw;
  logic  open_g;

  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    assign raw[b] = pend[b] & en[b] & ~idlg[b];
  end

  assign open_g = (priv != PRIV_MACH) || glob_mie;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      req_q <= 1'b0;
    end else begin
      vec_q <= open_g ? raw : '0;
      req_q <= open_g & (|raw);
    end
  end
endmodule

// File: rtl/irqcsr_unit.sv
module irqcsr_unit
  import irqcsr_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter bit LOCAL_IRQ_EN  = 1'b0,
  parameter int NUM_LOCAL_IRQ = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_req,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      cur_priv,
  input  logic            glob_mie,
  input  logic            timer_irq,
  output logic [XLEN-1:0] csr_rdata,
  output logic [11:0]     irq_vec,
  output logic            irq_req
);
  localparam int MAX_IRQ = 16 + (LOCAL_IRQ_EN ? NUM_LOCAL_IRQ : 0);
  localparam logic [XLEN-1:0] CAUSE_KEEP =
    (XLEN'(1) << (XLEN - 1)) | XLEN'(MAX_IRQ - 1);

  csr_sel_e        sel;
  irqv_t           rd_mask, en_wmask, pend_wmask;
  logic            priv_m;
  irqv_t           en_q, pend_q, idlg_q, view_dlg;
  logic [XLEN-1:0] edlg_q, caus_q, thrs_q, rd_val;

  irqcsr_decode u_dec (
    .addr(csr_addr), .priv(cur_priv), .sel(sel), .rd_mask(rd_mask),
    .en_wmask(en_wmask), .pend_wmask(pend_wmask), .priv_m(priv_m)
  );

  irqcsr_regs #(.XLEN(XLEN), .CAUSE_KEEP(CAUSE_KEEP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(csr_req & csr_we), .sel(sel),
    .wdata(csr_wdata), .en_wmask(en_wmask), .pend_wmask(pend_wmask),
    .timer_irq(timer_irq), .en_q(en_q), .pend_q(pend_q), .idlg_q(idlg_q),
    .edlg_q(edlg_q), .caus_q(caus_q), .thrs_q(thrs_q)
  );

  irqcsr_gate u_gate (
    .clk(clk), .rst(rst), .pend(pend_q), .en(en_q), .idlg(idlg_q),
    .priv(cur_priv), .glob_mie(glob_mie), .vec_q(irq_vec), .req_q(irq_req)
  );

  assign view_dlg = priv_m ? {IRQ_W{1'b1}} : idlg_q;

  always_comb begin
    unique case (sel)
      SEL_EN:   rd_val = XLEN'(en_q & rd_mask & view_dlg);
      SEL_PEND: rd_val = XLEN'(pend_q & rd_mask & view_dlg);
      SEL_IDLG: rd_val = XLEN'(idlg_q);
      SEL_EDLG: rd_val = edlg_q;
      SEL_CAUS: rd_val = caus_q;
      SEL_THRS: rd_val = thrs_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          csr_rdata <= '0;
    else if (csr_req) csr_rdata <= rd_val;
  end
endmodule

// File: rtl/irqcsr_unit_chk.sv
module irqcsr_unit_chk #(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] CAUSE_KEEP = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            csr_req,
  input logic            timer_irq,
  input logic            glob_mie,
  input logic [1:0]      cur_priv,
  input logic [XLEN-1:0] csr_rdata,
  input logic [11:0]     irq_vec,
  input logic            irq_req,
  input logic [11:0]     pend_q,
  input logic [11:0]     idlg_q,
  input logic [XLEN-1:0] edlg_q,
  input logic [XLEN-1:0] caus_q,
  input logic [XLEN-1:0] thrs_q
);
  a_r5_timer_follows_line: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pend_q[7] == $past(timer_irq));

  a_r7_deleg_user_only: assert property (@(posedge clk) disable iff (rst)
    (idlg_q & ~12'h111) == 12'h000);

  a_r8_edeleg_holes: assert property (@(posedge clk) disable iff (rst)
    (edlg_q & ~XLEN'(16'hF7F7)) == '0);

  a_r9_cause_width: assert property (@(posedge clk) disable iff (rst)
    (caus_q & ~CAUSE_KEEP) == '0);

  a_r10_thresh_byte: assert property (@(posedge clk) disable iff (rst)
    (thrs_q >> 8) == '0);

  a_r11_gate_closed: assert property (@(posedge clk) disable iff (rst)
    (cur_priv == 2'b11 && !glob_mie) |=> irq_vec == 12'h000);

  a_r12_req_is_or: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_vec != 12'h000));

  a_r13_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !csr_req |=> $stable(csr_rdata));
endmodule

bind irqcsr_unit irqcsr_unit_chk #(.XLEN(XLEN), .CAUSE_KEEP(CAUSE_KEEP)) u_chk (
  .clk(clk), .rst(rst), .csr_req(csr_req), .timer_irq(timer_irq),
  .glob_mie(glob_mie), .cur_priv(cur_priv), .csr_rdata(csr_rdata),
  .irq_vec(irq_vec), .irq_req(irq_req), .pend_q(pend_q), .idlg_q(idlg_q),
  .edlg_q(edlg_q), .caus_q(caus_q), .thrs_q(thrs_q)
);

// File: tb/irqcsr_unit_bench.sv
`timescale 1ns/1ps
module irqcsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_req = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [1:0]  cur_priv = 2'd3;
  logic        glob_mie = 1'b0, timer_irq = 1'b0;
  logic [31:0] csr_rdata;
  logic [11:0] irq_vec;
  logic        irq_req;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [11:0] m_en = '0, m_pend = '0, m_idlg = '0;
  logic [31:0] m_edlg = '0, m_caus = '0, m_thrs = '0;

  always #10 clk = ~clk;

  irqcsr_unit u_irqcsr_unit (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .cur_priv(cur_priv),
    .glob_mie(glob_mie), .timer_irq(timer_irq), .csr_rdata(csr_rdata),
    .irq_vec(irq_vec), .irq_req(irq_req)
  );

  function automatic logic [11:0] lvl_m(input logic [1:0] l);
    case (l)
      2'd0: return 12'h111;
      2'd1: return 12'h333;
      2'd2: return 12'h000;
      default: return 12'h999;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [11:0] view;
    view = (cur_priv == 2'd3) ? 12'hFFF : m_idlg;
    if (a[11:10] == 2'b00 && a[7:0] == 8'h04) return {20'h0, m_en & lvl_m(a[9:8]) & view};
    if (a[11:10] == 2'b00 && a[7:0] == 8'h44) return {20'h0, m_pend & lvl_m(a[9:8]) & view};
    if (a == 12'h303) return {20'h0, m_idlg};
    if (a == 12'h302) return m_edlg;
    if (a == 12'h342) return m_caus;
    if (a == 12'h347) return m_thrs;
    return 32'h0;
  endfunction

  function automatic logic [11:0] exp_vec();
    if (cur_priv != 2'd3 || glob_mie) return m_pend & m_en & ~m_idlg;
    return 12'h000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_timer(input logic v);
    timer_irq = v;
    m_pend[7] = v;
  endtask

  // Starts just after a falling edge; returns at the next falling edge.
  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    logic [11:0] lm, wm;
    csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    lm = lvl_m(a[9:8]);
    if (a[11:10] == 2'b00 && a[7:0] == 8'h04)
      m_en = (m_en & ~lm) | (d[11:0] & lm);
    else if (a[11:10] == 2'b00 && a[7:0] == 8'h44) begin
      wm = lm & ~12'h080;
      if (cur_priv != 2'd3) wm = wm & ~12'h030;
      m_pend = (m_pend & ~wm) | (d[11:0] & wm);
    end
    else if (a == 12'h303) m_idlg = (m_idlg & ~12'h111) | (d[11:0] & 12'h111);
    else if (a == 12'h302) m_edlg = (m_edlg & ~32'hF7F7) | (d & 32'hF7F7);
    else if (a == 12'h342) m_caus = d & (32'h8000_0000 | 32'(16 - 1));
    else if (a == 12'h347) m_thrs = d & 32'hFF;
    @(negedge clk);
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    e = exp_rd(a);
    csr_req = 1'b1; csr_we = 1'b0; csr_addr = a;
    @(negedge clk);
    csr_req = 1'b0;
    check(tag, csr_rdata, e);
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] e, input string tag);
    csr_req = 1'b1; csr_we = 1'b0; csr_addr = a;
    @(negedge clk);
    csr_req = 1'b0;
    check(tag, csr_rdata, e);
  endtask

  task automatic check_vec(input string tag);
    check(tag, {20'h0, irq_vec}, {20'h0, exp_vec()});
    check(tag, {31'h0, irq_req}, {31'h0, exp_vec() != 12'h000});
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] pat;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 rdata", csr_rdata, 32'h0);
    check("R1 vec", {20'h0, irq_vec}, 32'h0);
    check("R1 req", {31'h0, irq_req}, 32'h0);
    rd_expect(12'h304, 32'h0, "R1 en");
    rd_expect(12'h344, 32'h0, "R1 pend");
    rd_expect(12'h303, 32'h0, "R1 ideleg");
    rd_expect(12'h342, 32'h0, "R1 cause");

    // R2 R3 R4 R6 R11: sweep over view, privilege and patterns
    for (int wl = 0; wl < 4; wl++)
      for (int pr = 0; pr < 4; pr++)
        for (int pi = 0; pi < 3; pi++) begin
          pat = (pi == 0) ? 12'hFFF : (pi == 1) ? 12'hA5A : 12'h5A5;
          cur_priv = 2'(pr);
          glob_mie = pi[0];
          csr_wr(12'h303, {20'h0, ~pat});
          csr_wr({2'b00, 2'(wl), 8'h04}, {20'h0, pat});
          csr_wr({2'b00, 2'(wl), 8'h44}, {20'h0, pat ^ 12'h0F0});
          @(negedge clk);
          check_vec("R11 sweep vec");
          for (int rl = 0; rl < 4; rl++) begin
            csr_rd({2'b00, 2'(rl), 8'h04}, "R2 R3 R4 en view");
            csr_rd({2'b00, 2'(rl), 8'h44}, "R2 R3 R4 R6 pend view");
          end
        end

    // R6: timer bits 4/5 frozen outside machine mode
    cur_priv = 2'd3;
    csr_wr(12'h144, 32'h0);
    cur_priv = 2'd0;
    csr_wr(12'h144, 32'hFFF);
    cur_priv = 2'd3;
    rd_expect(12'h144, 32'h303, "R6 user write keeps timer bits");

    // R5: timer line owns bit 7
    set_timer(1'b1);
    @(negedge clk);
    rd_expect(12'h344, {20'h0, m_pend & 12'h999}, "R5 timer sets bit7");
    check("R5 bit7", {31'h0, csr_rdata[7]}, 32'h1);
    csr_wr(12'h344, 32'h0);
    rd_expect(12'h344, 32'h080, "R5 software clear ignored");
    set_timer(1'b0);
    csr_wr(12'h344, 32'hFFF);
    rd_expect(12'h344, 32'h919, "R5 same-edge write and timer fall");

    // R7 R8 R9 R10 R13
    csr_wr(12'h303, 32'hFFFF_FFFF);
    rd_expect(12'h303, 32'h111, "R7 ideleg mask");
    csr_wr(12'h302, 32'hFFFF_FFFF);
    rd_expect(12'h302, 32'h0000_F7F7, "R8 edeleg mask");
    csr_wr(12'h342, 32'hFFFF_FFFF);
    rd_expect(12'h342, 32'h8000_000F, "R9 cause mask");
    csr_wr(12'h342, 32'h0000_0017);
    rd_expect(12'h342, 32'h0000_0007, "R9 cause code");
    csr_wr(12'h347, 32'h0000_1234);
    rd_expect(12'h347, 32'h0000_0034, "R10 threshold byte");
    rd_expect(12'h123, 32'h0, "R13 unknown address");
    rd_expect(12'h347, 32'h34, "R13 reload");
    held = csr_rdata;
    repeat (3) @(negedge clk);
    check("R13 rdata holds", csr_rdata, held);

    // R11 R12: gating and latency
    cur_priv = 2'd3; glob_mie = 1'b0;
    csr_wr(12'h104, 32'h0);
    csr_wr(12'h304, 32'h0);
    csr_wr(12'h144, 32'h0);
    csr_wr(12'h344, 32'h0);
    csr_wr(12'h304, 32'hFFF);
    csr_wr(12'h344, 32'hFFF);
    csr_wr(12'h303, 32'h001);
    @(negedge clk);
    check("R11 closed in machine mode", {20'h0, irq_vec}, 32'h0);
    glob_mie = 1'b1;
    @(negedge clk);
    check("R11 open vec", {20'h0, irq_vec}, 32'h918);
    check("R12 req high", {31'h0, irq_req}, 32'h1);
    csr_wr(12'h304, 32'h0);
    check("R12 vec one cycle late", {20'h0, irq_vec}, 32'h918);
    @(negedge clk);
    check("R12 vec cleared", {20'h0, irq_vec}, 32'h0);
    check("R12 req cleared", {31'h0, irq_req}, 32'h0);
    csr_wr(12'h304, 32'hFFF);
    cur_priv = 2'd0; glob_mie = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 open below machine", {20'h0, irq_vec}, 32'h918);
    check_vec("R11 model");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule